// File: doc/BRIEF.md
# Mixed-Size Memory Bank Chip-Enable Decoder

This block drives eight active-low chip enables for the external memory banks of a removable memory card. It works out which bank an access targets from a three-bit high-address field, a two-bit region field and a map-mode strap. The resulting enable goes low only for an access to the card's common (main) memory space. In flat mode the three address bits pick one of eight equal banks. Mixed mode lets small and large devices share one contiguous address space. Region zero maps four small banks, chosen by the two low address bits. The three other region codes each map one large bank directly.

The decode path is combinational from the inputs to the enables. A small counter sits beside it. This counter holds every enable inactive while reset is high and for a fixed number of clock edges after reset is released. That window stops a stray write from reaching memory while the card is powering up. No data moves through the block, so it has no valid/ready handshake. All of its pins are plain control levels.

Top module: `memcard_ce_decoder`

## Requirements
- R1: With `flat_map` high, the bank whose index equals `addr_hi` (0..7) drives its `bank_en_n` bit low, and all other bits stay high.
- R2: With `flat_map` low and `region_sel` = 2'b00, the bank whose index equals `addr_hi[1:0]` (bits 0..3) goes low. `addr_hi[2]` has no effect on the result.
- R3: With `flat_map` low, `region_sel` values 2'b01, 2'b10 and 2'b11 select `bank_en_n[5]`, `bank_en_n[6]` and `bank_en_n[7]` respectively. `addr_hi` has no effect.
- R4: With `flat_map` low, `bank_en_n[4]` is never low.
- R5: While `attr_sel_n` is low (attribute space), all `bank_en_n` bits are high.
- R6: While both `lane_even_n` and `lane_odd_n` are high, all bits are high. Either one low is enough to enable a bank.
- R7: While `rst` is high, all `bank_en_n` bits are high.
- R8: After `rst` falls, all bits stay high until LOCK_CYCLES rising edges of `clk` have been seen with `rst` low. Decoding starts in the cycle that follows those edges.
- R9: At most one `bank_en_n` bit is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the power-up lockout counter |
| rst | input | 1 | Active-high reset; also forces all enables inactive |
| addr_hi | input | 3 | High address field used as the bank index |
| region_sel | input | 2 | Region field; in mixed mode picks small-bank area or a large bank |
| flat_map | input | 1 | 1 = flat one-of-eight map, 0 = mixed small/large map |
| attr_sel_n | input | 1 | 1 = common memory access, 0 = attribute space (no enable) |
| lane_even_n | input | 1 | Active-low even byte lane strobe |
| lane_odd_n | input | 1 | Active-low odd byte lane strobe |
| bank_en_n | output | 8 | Active-low bank chip enables |

## Verification
Every decode result follows the inputs within the same cycle. The bench therefore changes the inputs 1 ns after a rising edge and compares `bank_en_n` at the next falling edge. The lockout is the only timed result. It is due after exactly LOCK_CYCLES rising edges with reset low. The bench counts those same edges in its own model and compares every cycle on both sides of the boundary. This pins down off-by-one errors in either direction. All 512 combinations of mode, region, address, space and lane strobes are applied after unlock. A second reset in the middle of the run shows that the lockout starts again.

// File: rtl/ce_decode_pkg.sv
package ce_decode_pkg;
  localparam int IDX_W     = 3;
  localparam int REGION_W  = 2;
  localparam int NUM_BANKS = 1 << IDX_W;
  localparam int SMALL_W   = REGION_W;
  localparam int NUM_SMALL = 1 << SMALL_W;

  typedef logic [IDX_W-1:0]     bank_idx_t;
  typedef logic [NUM_BANKS-1:0] bank_vec_t;

  typedef enum logic {
    MAP_MIXED = 1'b0,
    MAP_FLAT  = 1'b1
  } map_mode_e;
endpackage

// File: rtl/ce_lockout.sv
module ce_lockout #(
  parameter int LOCK_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  output logic locked
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LOCK_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q < LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign locked = rst | (cnt_q < LIMIT);
endmodule

// File: rtl/ce_bank_resolve.sv
module ce_bank_resolve
  import ce_decode_pkg::*;
(
  input  logic [IDX_W-1:0]    addr_hi,
  input  logic [REGION_W-1:0] region_sel,
  input  map_mode_e           mode,
  output bank_idx_t           bank_idx
);
  bank_idx_t mixed_idx;

  always_comb begin
    if (region_sel == '0) begin
      // small banks fill the lowest part of the map
      mixed_idx = IDX_W'(addr_hi[SMALL_W-1:0]);
    end else begin
      // each further region code is one large bank above the small ones
      mixed_idx = IDX_W'(NUM_SMALL) + IDX_W'(region_sel);
    end
  end

  assign bank_idx = (mode == MAP_FLAT) ? addr_hi : mixed_idx;
endmodule

// File: rtl/ce_onehot_dec.sv
module ce_onehot_dec
  import ce_decode_pkg::*;
(
  input  bank_idx_t bank_idx,
  input  logic      enable,
  output bank_vec_t sel_n
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign sel_n[g] = ~(enable & (bank_idx == IDX_W'(g)));
  end
endmodule

// File: rtl/memcard_ce_decoder.sv
module memcard_ce_decoder
  import ce_decode_pkg::*;
#(
  parameter int LOCK_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] addr_hi,
  input  logic [1:0] region_sel,
  input  logic       flat_map,
  input  logic       attr_sel_n,
  input  logic       lane_even_n,
  input  logic       lane_odd_n,
  output logic [7:0] bank_en_n
);
  logic      locked;
  logic      access;
  bank_idx_t bank_idx;
  map_mode_e mode;

  assign mode   = flat_map ? MAP_FLAT : MAP_MIXED;
  assign access = attr_sel_n & ~(lane_even_n & lane_odd_n) & ~locked;

  ce_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lockout (
    .clk    (clk),
    .rst    (rst),
    .locked (locked)
  );

  ce_bank_resolve u_resolve (
    .addr_hi    (addr_hi),
    .region_sel (region_sel),
    .mode       (mode),
    .bank_idx   (bank_idx)
  );

  ce_onehot_dec u_dec (
    .bank_idx (bank_idx),
    .enable   (access),
    .sel_n    (bank_en_n)
  );
endmodule

// File: rtl/memcard_ce_decoder_chk.sv
module memcard_ce_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] addr_hi,
  input logic [1:0] region_sel,
  input logic       flat_map,
  input logic       attr_sel_n,
  input logic       lane_even_n,
  input logic       lane_odd_n,
  input logic       locked,
  input logic [7:0] bank_en_n
);
  // R9
  one_bank_chk: assert property (@(posedge clk) $countones(~bank_en_n) <= 1);

  // R7
  reset_idle_chk: assert property (@(posedge clk) rst |-> (bank_en_n == 8'hFF));

  // R8
  unlock_wait_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bank_en_n == 8'hFF));

  // R5
  attr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !attr_sel_n |-> (bank_en_n == 8'hFF));

  // R6
  no_lane_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_even_n && lane_odd_n) |-> (bank_en_n == 8'hFF));

  // R4
  bank4_unused_chk: assert property (@(posedge clk) disable iff (rst)
    !flat_map |-> bank_en_n[4]);

  // R1
  flat_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (flat_map && attr_sel_n && !(lane_even_n && lane_odd_n) && !locked)
      |-> !bank_en_n[addr_hi]);

  // R3
  large_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (!flat_map && region_sel != 2'b00 && attr_sel_n && !(lane_even_n && lane_odd_n) && !locked)
      |-> !bank_en_n[{1'b1, region_sel}]);
endmodule

bind memcard_ce_decoder memcard_ce_decoder_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .addr_hi     (addr_hi),
  .region_sel  (region_sel),
  .flat_map    (flat_map),
  .attr_sel_n  (attr_sel_n),
  .lane_even_n (lane_even_n),
  .lane_odd_n  (lane_odd_n),
  .locked      (locked),
  .bank_en_n   (bank_en_n)
);

// File: tb/memcard_ce_decoder_bench.sv
`timescale 1ns/1ps
module memcard_ce_decoder_bench;
  localparam int LOCK = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr_hi = '0;
  logic [1:0] region_sel = '0;
  logic       flat_map = 1'b1;
  logic       attr_sel_n = 1'b1;
  logic       lane_even_n = 1'b0;
  logic       lane_odd_n = 1'b1;
  logic [7:0] bank_en_n;

  int vectors = 0;
  int misses  = 0;
  int edges_free = 0;

  always #2.5 clk = ~clk;

  memcard_ce_decoder #(.LOCK_CYCLES(LOCK)) u_memcard_ce_decoder (
    .clk(clk), .rst(rst), .addr_hi(addr_hi), .region_sel(region_sel),
    .flat_map(flat_map), .attr_sel_n(attr_sel_n), .lane_even_n(lane_even_n),
    .lane_odd_n(lane_odd_n), .bank_en_n(bank_en_n)
  );

  // reference: count rising edges seen with reset low
  always @(posedge clk) begin
    if (rst) edges_free <= 0;
    else if (edges_free < LOCK) edges_free <= edges_free + 1;
  end

  function automatic logic [7:0] model();
    int target;
    if (rst || edges_free < LOCK) return 8'hFF;
    if (!attr_sel_n) return 8'hFF;
    if (lane_even_n && lane_odd_n) return 8'hFF;
    if (flat_map) target = addr_hi;
    else begin
      case (region_sel)
        2'd0: target = addr_hi % 4;
        2'd1: target = 5;
        2'd2: target = 6;
        default: target = 7;
      endcase
    end
    return ~(8'd1 << target);
  endfunction

  function automatic string tag();
    if (rst) return "R7";
    if (edges_free < LOCK) return "R8";
    if (!attr_sel_n) return "R5";
    if (lane_even_n && lane_odd_n) return "R6";
    if (flat_map) return "R1";
    if (region_sel == 2'd0) return "R2";
    return "R3";
  endfunction

  task automatic compare();
    logic [7:0] exp_v;
    exp_v = model();
    vectors++;
    if (bank_en_n !== exp_v) begin
      misses++;
      $display("FAIL %s: bank_en_n=%b expected %b (flat=%b region=%0d addr=%0d attr_n=%b lanes_n=%b%b)",
               tag(), bank_en_n, exp_v, flat_map, region_sel, addr_hi, attr_sel_n,
               lane_odd_n, lane_even_n);
    end
    if (!flat_map && bank_en_n[4] !== 1'b1) begin
      misses++;
      $display("FAIL R4: bank_en_n[4]=%b expected 1", bank_en_n[4]);
    end
    if ($countones(~bank_en_n) > 1) begin
      misses++;
      $display("FAIL R9: bank_en_n=%b has %0d low bits, expected at most 1",
               bank_en_n, $countones(~bank_en_n));
    end
  endtask

  task automatic step(input logic f, input logic [1:0] r, input logic [2:0] a,
                      input logic at, input logic [1:0] ln);
    @(posedge clk);
    #1;
    flat_map = f; region_sel = r; addr_hi = a; attr_sel_n = at;
    lane_odd_n = ln[1]; lane_even_n = ln[0];
    @(negedge clk);
    compare();
  endtask

  task automatic reset_and_unlock(input logic [2:0] a);
    rst = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b1, 2'd0, a, 1'b1, 2'b10); // R7 with an access applied
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk); compare();
    // R8: access held through lockout boundary
    for (int i = 0; i < LOCK + 3; i++) step(1'b1, 2'd0, a, 1'b1, 2'b01);
  endtask

  initial begin
    reset_and_unlock(3'd2);
    // full sweep: R1 R2 R3 R4 R5 R6 R9
    for (int f = 0; f < 2; f++)
      for (int r = 0; r < 4; r++)
        for (int a = 0; a < 8; a++)
          for (int at = 0; at < 2; at++)
            for (int ln = 0; ln < 4; ln++)
              step(f[0], r[1:0], a[2:0], at[0], ln[1:0]);
    // R2: addr_hi[2] ignored in small-bank region
    step(1'b0, 2'd0, 3'd6, 1'b1, 2'b00);
    step(1'b0, 2'd0, 3'd2, 1'b1, 2'b00);
    // R3: large bank ignores address
    step(1'b0, 2'd3, 3'd4, 1'b1, 2'b10);
    // R7/R8: reset mid-run restarts the lockout
    reset_and_unlock(3'd7);
    step(1'b0, 2'd1, 3'd0, 1'b1, 2'b00);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    misses++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule